// File: doc/BRIEF.md
# Multi-Mode Acquisition Sequencer with Header Detection

This block decides when sampled ADC data is pushed into a downstream 2K-word FIFO. Each clock it sees one sample from each of four 8-bit ADC channels and can pack them into a single 32-bit word. A 2-bit mode input selects one of four capture behaviours. In free-run mode, a trigger starts a continuous stream that fills the FIFO. In windowed mode, a trigger starts a burst of fixed length. In the two header modes, the engine looks for a four-symbol synchronisation header on channel 0 and then writes a tag word followed by a fixed-length event. The search either waits for a trigger or runs on its own.

The header symbols come from two thresholds. A sample at or below the low threshold reads as a logic 0. A sample at or above the high threshold reads as a logic 1. Anything in between breaks the match. The tag word carries the current trigger count, so readout software can align events with triggers.

The block drives the FIFO write strobe and data directly and raises `busy` while a capture is in progress. Trigger qualification happens upstream: the `trig` input is already an accepted pulse.

Top module: `acq_seq`

## Requirements
- R1: After reset the block is idle: `busy` and `wr_en` are low until a capture starts.
- R2: A data word carries channel k in bits 8k+7..8k (channel 0 in 7..0, channel 3 in 31..24).
- R3: With mode 00, a trigger seen at a clock edge starts a write of the current samples on every following cycle. `busy` is high throughout. The run ends after 2048 writes or when the FIFO reports full.
- R4: With mode 11, a trigger starts exactly 256 consecutive writes, after which `busy` drops. A full FIFO cuts the run short.
- R5: With mode 01, a trigger raises `busy` and starts a header search on channel 0. A sample is a 0 when it is at or below `thr_lo` and a 1 when it is at or above `thr_hi`. The header is 0,1,0,1 in four consecutive cycles, oldest first. A sample between the thresholds restarts the match.
- R6: In the cycle after the cycle that carries the last header sample, the block writes a tag word. The tag holds `trig_count` in bits 11..0 and zeros in bits 31..12.
- R7: After the tag come 144 event words. The first is the sample presented in the tag cycle, and each later word is the next cycle's sample. `busy` drops after the last one.
- R8: With mode 10, the header search runs without a trigger and `busy` stays low while searching. Triggers are ignored. Once an event is written, searching resumes.
- R9: `wr_en` is never high while `fifo_full` is high. A full FIFO during any write phase ends the capture, and the block returns to idle on the next cycle.
- R10: Triggers that arrive while a capture is in progress have no effect: the running capture keeps its length and no new capture starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Capture mode: 00 free-run, 01 trigger then header, 10 header only, 11 fixed window |
| thr_lo | input | 8 | Channel-0 level at or below which a sample is a 0 |
| thr_hi | input | 8 | Channel-0 level at or above which a sample is a 1 |
| trig | input | 1 | Accepted trigger pulse |
| trig_count | input | 12 | Current trigger count, copied into the tag word |
| adc_smp | input | 4x8 | One sample per channel, channel k at element k |
| fifo_full | input | 1 | Downstream FIFO cannot take a word |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | 32 | FIFO write data |
| busy | output | 1 | Capture in progress |

## Verification
Two functions can land in the same cycle: a FIFO filling up, and a write the sequencer has already committed to. The bench sets the FIFO occupancy so that the full flag rises exactly on a tag write, on the last word of a window, or in the middle of an event. It then checks that the stream is cut on that cycle and that the block returns to idle on the next one. The bench also pulses triggers on the final busy cycle of a window and during header search. A bench-side model predicts the strobe, data and `busy` on every cycle, and the write total of each scenario is compared with the expected length.

// File: rtl/acq_pkg.sv
`timescale 1ns/1ps
package acq_pkg;

    localparam int SMP_W  = 8;
    localparam int NCH    = 4;
    localparam int WORD_W = SMP_W * NCH;

    typedef enum logic [1:0] {
        MD_FREE     = 2'b00,
        MD_TRIG_HDR = 2'b01,
        MD_HDR      = 2'b10,
        MD_WIN      = 2'b11
    } acq_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_TAG,
        ST_EVENT,
        ST_STREAM
    } acq_state_e;

    typedef enum logic [1:0] {
        WS_STREAM,
        WS_TAG,
        WS_EVENT
    } wsel_e;

    typedef struct packed {
        logic vld;
        logic one;
    } sym_t;

    // Threshold window classification of one sample.
    function automatic sym_t classify(input logic [SMP_W-1:0] s,
                                      input logic [SMP_W-1:0] lo,
                                      input logic [SMP_W-1:0] hi);
        sym_t r;
        if (s <= lo) begin
            r.vld = 1'b1;
            r.one = 1'b0;
        end else if (s >= hi) begin
            r.vld = 1'b1;
            r.one = 1'b1;
        end else begin
            r.vld = 1'b0;
            r.one = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/acq_hdr_det.sv
`timescale 1ns/1ps
module acq_hdr_det
    import acq_pkg::*;
#(
    parameter int          HDR_LEN = 4,
    parameter logic [HDR_LEN-1:0] HDR_PAT = 4'b0101
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SMP_W-1:0] smp,
    input  logic [SMP_W-1:0] lo,
    input  logic [SMP_W-1:0] hi,
    output logic             hit
);
    localparam int HIST = HDR_LEN - 1;

    sym_t cur;
    sym_t hist [HIST];
    logic match;

    always_comb begin
        cur   = classify(smp, lo, hi);
        match = cur.vld && (cur.one == HDR_PAT[0]);
        for (int j = 0; j < HIST; j++) begin
            match = match && hist[j].vld && (hist[j].one == HDR_PAT[j+1]);
        end
        hit = en && match;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            for (int j = 0; j < HIST; j++) begin
                hist[j] <= '0;
            end
        end else begin
            hist[0] <= cur;
            for (int j = 1; j < HIST; j++) begin
                hist[j] <= hist[j-1];
            end
        end
    end

endmodule

// File: rtl/acq_ctrl.sv
`timescale 1ns/1ps
module acq_ctrl
    import acq_pkg::*;
#(
    parameter int FIFO_DEPTH = 2048,
    parameter int EVT_LEN    = 144,
    parameter int WIN_LEN    = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       trig,
    input  logic       fifo_full,
    input  logic       hdr_hit,
    output logic       search_en,
    output logic       wr_en,
    output wsel_e      wsel,
    output logic       busy
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [CNT_W-1:0] LIM_FREE = CNT_W'(FIFO_DEPTH - 1);
    localparam logic [CNT_W-1:0] LIM_WIN  = CNT_W'(WIN_LEN - 1);
    localparam logic [CNT_W-1:0] LIM_EVT  = CNT_W'(EVT_LEN - 1);

    acq_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             armed;
    acq_mode_e        md;
    logic             writing;

    assign md = acq_mode_e'(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            lim   <= '0;
            armed <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    cnt <= '0;
                    if (md == MD_HDR) begin
                        st    <= ST_SEARCH;
                        armed <= 1'b0;
                    end else if (trig) begin
                        if (md == MD_TRIG_HDR) begin
                            st    <= ST_SEARCH;
                            armed <= 1'b1;
                        end else begin
                            st  <= ST_STREAM;
                            lim <= (md == MD_WIN) ? LIM_WIN : LIM_FREE;
                        end
                    end
                end
                ST_SEARCH: begin
                    if (hdr_hit) begin
                        st <= ST_TAG;
                    end else if (md == MD_FREE || md == MD_WIN) begin
                        st <= ST_IDLE;
                    end
                end
                ST_TAG: begin
                    cnt <= '0;
                    st  <= fifo_full ? ST_IDLE : ST_EVENT;
                end
                ST_EVENT: begin
                    if (fifo_full || cnt == LIM_EVT) begin
                        st <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_STREAM: begin
                    if (fifo_full || cnt == lim) begin
                        st <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        writing   = (st == ST_TAG) || (st == ST_EVENT) || (st == ST_STREAM);
        wr_en     = writing && !fifo_full;
        busy      = writing || ((st == ST_SEARCH) && armed);
        search_en = (st == ST_SEARCH);
        case (st)
            ST_TAG:   wsel = WS_TAG;
            ST_EVENT: wsel = WS_EVENT;
            default:  wsel = WS_STREAM;
        endcase
    end

endmodule

// File: rtl/acq_wmux.sv
`timescale 1ns/1ps
module acq_wmux
    import acq_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCH-1:0][SMP_W-1:0]  smp,
    input  logic [TAG_W-1:0]           tag,
    input  wsel_e                      wsel,
    output logic [WORD_W-1:0]          data
);
    logic [WORD_W-1:0] now_word;
    logic [WORD_W-1:0] dly_word;

    assign now_word = smp;

    // One-cycle delay so the event body starts with the sample that
    // shared its cycle with the tag write.
    always_ff @(posedge clk) begin
        if (rst) begin
            dly_word <= '0;
        end else begin
            dly_word <= now_word;
        end
    end

    always_comb begin
        case (wsel)
            WS_TAG:   data = {{(WORD_W-TAG_W){1'b0}}, tag};
            WS_EVENT: data = dly_word;
            default:  data = now_word;
        endcase
    end

endmodule

// File: rtl/acq_seq.sv
`timescale 1ns/1ps
module acq_seq
    import acq_pkg::*;
#(
    parameter int FIFO_DEPTH = 2048,
    parameter int EVT_LEN    = 144,
    parameter int WIN_LEN    = 256,
    parameter int TAG_W      = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                mode,
    input  logic [SMP_W-1:0]          thr_lo,
    input  logic [SMP_W-1:0]          thr_hi,
    input  logic                      trig,
    input  logic [TAG_W-1:0]          trig_count,
    input  logic [NCH-1:0][SMP_W-1:0] adc_smp,
    input  logic                      fifo_full,
    output logic                      wr_en,
    output logic [WORD_W-1:0]         wr_data,
    output logic                      busy
);
    logic  search_en;
    logic  det_hit;
    wsel_e wsel;

    acq_hdr_det u_det (
        .clk (clk),
        .rst (rst),
        .en  (search_en),
        .smp (adc_smp[0]),
        .lo  (thr_lo),
        .hi  (thr_hi),
        .hit (det_hit)
    );

    acq_ctrl #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .EVT_LEN    (EVT_LEN),
        .WIN_LEN    (WIN_LEN)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .trig      (trig),
        .fifo_full (fifo_full),
        .hdr_hit   (det_hit),
        .search_en (search_en),
        .wr_en     (wr_en),
        .wsel      (wsel),
        .busy      (busy)
    );

    acq_wmux #(
        .TAG_W (TAG_W)
    ) u_wmux (
        .clk  (clk),
        .rst  (rst),
        .smp  (adc_smp),
        .tag  (trig_count),
        .wsel (wsel),
        .data (wr_data)
    );

endmodule

// File: rtl/acq_seq_chk.sv
`timescale 1ns/1ps
module acq_seq_chk #(
    parameter int WIN_LEN = 256,
    parameter int TAG_W   = 12
) (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  mode,
    input logic        trig,
    input logic        fifo_full,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic        busy,
    input logic        det_hit
);
    localparam int RW = $clog2(WIN_LEN + 2);

    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_len <= '0;
        end else if (wr_en) begin
            run_len <= run_len + 1'b1;
        end
    end

    // R9: the strobe and the full flag never coincide
    a_r9_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !wr_en);

    // R6: a write right after a detected header is a zero-padded tag
    a_r6_tag_upper_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(det_hit) && wr_en) |-> (wr_data[31:TAG_W] == '0));

    // R4: a window capture never runs past its length while busy
    a_r4_window_bound: assert property (@(posedge clk) disable iff (rst)
        (busy && mode == 2'b11) |-> (run_len < RW'(WIN_LEN)));

    // R3: outside header-only mode, busy only rises after a trigger
    a_r3_start_on_trigger: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && mode != 2'b10) |-> $past(trig));

endmodule

bind acq_seq acq_seq_chk #(
    .WIN_LEN (WIN_LEN),
    .TAG_W   (TAG_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .trig      (trig),
    .fifo_full (fifo_full),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .busy      (busy),
    .det_hit   (det_hit)
);

// File: tb/acq_seq_tb.sv
`timescale 1ns/1ps
module acq_seq_tb;

    localparam int DEPTH = 2048;
    localparam int EVT   = 144;
    localparam int WIN   = 256;

    logic            clk = 1'b0;
    logic            rst;
    logic [1:0]      mode;
    logic [7:0]      thr_lo, thr_hi;
    logic            trig;
    logic [11:0]     trig_count;
    logic [3:0][7:0] adc_smp;
    logic            fifo_full;
    logic            wr_en;
    logic [31:0]     wr_data;
    logic            busy;

    always #2.5 clk = ~clk;

    acq_seq u_dut (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .thr_lo     (thr_lo),
        .thr_hi     (thr_hi),
        .trig       (trig),
        .trig_count (trig_count),
        .adc_smp    (adc_smp),
        .fifo_full  (fifo_full),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .busy       (busy)
    );

    int n_chk = 0;
    int n_bad = 0;
    int occ = 0;
    int seen = 0;
    // bench-side model: 0 idle, 1 search, 2 tag, 3 event, 4 stream
    int ms = 0, mcnt = 0, mlim = 0, marmed = 0;
    int h0 = -1, h1 = -1, h2 = -1;
    logic [31:0] prev_word = '0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int cls(input logic [7:0] s);
        if (s <= thr_lo) return 0;
        if (s >= thr_hi) return 1;
        return -1;
    endfunction

    function automatic string req_of();
        case (ms)
            2: return "R6";
            3: return "R7";
            4: return (mlim == WIN) ? "R4" : "R3";
            default: return (mode == 2'b10) ? "R8" : "R5";
        endcase
    endfunction

    task automatic tick();
        bit          act, ew, eb;
        logic [31:0] ed;
        int          c;
        fifo_full = (occ >= DEPTH);
        #1;
        if (rst) begin
            ms = 0; mcnt = 0; mlim = 0; marmed = 0; h0 = -1; h1 = -1; h2 = -1;
            prev_word = '0;
        end else begin
            act = (ms >= 2);
            ew  = act && !fifo_full;
            eb  = act || (ms == 1 && marmed != 0);
            ed  = (ms == 2) ? {20'd0, trig_count} : (ms == 3) ? prev_word : adc_smp;
            check(busy == eb, req_of(), 32'(busy), 32'(eb));
            check(wr_en == ew, fifo_full ? "R9" : req_of(), 32'(wr_en), 32'(ew));
            if (wr_en && ew) begin
                check(wr_data == ed, (ms == 4) ? "R2" : req_of(), wr_data, ed);
            end
            if (wr_en) seen++;
            if (ew) occ++;
            c = cls(adc_smp[0]);
            case (ms)
                0: begin
                    mcnt = 0;
                    if (mode == 2'b10) begin ms = 1; marmed = 0; end
                    else if (trig) begin
                        if (mode == 2'b01) begin ms = 1; marmed = 1; end
                        else begin ms = 4; mlim = (mode == 2'b11) ? WIN : DEPTH; end
                    end
                    h0 = -1; h1 = -1; h2 = -1;
                end
                1: begin
                    if (c == 1 && h0 == 0 && h1 == 1 && h2 == 0) ms = 2;
                    else if (mode == 2'b00 || mode == 2'b11) ms = 0;
                    else begin h2 = h1; h1 = h0; h0 = c; end
                end
                2: begin mcnt = 0; ms = fifo_full ? 0 : 3; end
                3: begin
                    if (fifo_full || mcnt == EVT - 1) ms = 0; else mcnt++;
                end
                default: begin
                    if (fifo_full || mcnt == mlim - 1) ms = 0; else mcnt++;
                end
            endcase
            if (ms != 1) begin h0 = -1; h1 = -1; h2 = -1; end
            prev_word = adc_smp;
        end
        @(negedge clk);
    endtask

    task automatic rand_adc();
        adc_smp = $urandom;
    endtask

    task automatic set_ch0(input logic [7:0] v);
        adc_smp = $urandom;
        adc_smp[0] = v;
    endtask

    task automatic wait_idle();
        trig = 1'b0;
        while (ms >= 2 || (ms == 1 && marmed != 0)) begin
            rand_adc();
            tick();
        end
    endtask

    task automatic fire();
        trig = 1'b1;
        rand_adc();
        tick();
        trig = 1'b0;
    endtask

    initial begin
        #750000;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; mode = 2'b00; thr_lo = 8'd40; thr_hi = 8'd200;
        trig = 1'b0; trig_count = 12'h5A3; adc_smp = '0;
        @(negedge clk);
        repeat (4) tick();
        rst = 1'b0;
        tick();
        // R1: idle after reset
        check(busy == 1'b0 && wr_en == 1'b0, "R1", {busy, wr_en}, 32'd0);

        // R3: free-run fills the FIFO with exactly DEPTH words
        occ = 0; seen = 0;
        fire();
        wait_idle();
        check(seen == DEPTH, "R3", seen, DEPTH);

        // R3 / R9: free-run cut short by an almost full FIFO
        occ = DEPTH - 8; seen = 0;
        fire();
        wait_idle();
        check(seen == 8, "R9", seen, 8);

        // R4 / R10: window of 256 with triggers during the run and on its last cycle
        occ = 0; seen = 0; mode = 2'b11;
        fire();
        while (ms == 4) begin
            trig = (($urandom % 7) == 0) || (mcnt == WIN - 1);
            rand_adc();
            tick();
        end
        trig = 1'b0;
        check(seen == WIN, "R10", seen, WIN);
        tick();
        check(busy == 1'b0, "R4", busy, 0);

        // R4 / R9: full lands on the last word of a window
        occ = DEPTH - WIN; seen = 0;
        fire();
        wait_idle();
        check(seen == WIN, "R4", seen, WIN);
        occ = 0;

        // R5 / R6 / R7: trigger, broken header, then a true one at the thresholds
        mode = 2'b01; seen = 0; trig_count = 12'h7C1;
        fire();
        check(busy == 1'b1 || ms == 1, "R5", busy, 1);
        set_ch0(8'd40);  tick();
        set_ch0(8'd200); tick();
        set_ch0(8'd41);  tick();
        set_ch0(8'd199); tick();
        set_ch0(8'd10);  tick();
        set_ch0(8'd255); tick();
        set_ch0(8'd0);   tick();
        check(ms == 1, "R5", ms, 1);
        set_ch0(8'd220); tick();
        check(ms == 2, "R5", ms, 2);
        wait_idle();
        check(seen == EVT + 1, "R7", seen, EVT + 1);

        // R9: full rises right after the tag write
        occ = DEPTH - 1; seen = 0;
        fire();
        set_ch0(8'd0); tick(); set_ch0(8'd255); tick();
        set_ch0(8'd0); tick(); set_ch0(8'd255); tick();
        wait_idle();
        check(seen == 1, "R6", seen, 1);

        // R9: truncation in the middle of an event
        occ = DEPTH - 30; seen = 0;
        fire();
        set_ch0(8'd0); tick(); set_ch0(8'd255); tick();
        set_ch0(8'd0); tick(); set_ch0(8'd255); tick();
        wait_idle();
        check(seen == 30, "R9", seen, 30);

        // R8: header-only mode with random symbols and stray triggers
        occ = 0; mode = 2'b10;
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 5;
            trig = (($urandom % 11) == 0);
            trig_count = $urandom;
            set_ch0(r < 2 ? 8'($urandom % 41) : r < 4 ? 8'(200 + $urandom % 56) : 8'd120);
            if (($urandom % 9) == 0 && !busy) occ = (occ > 3) ? occ - 3 : 0;
            tick();
        end
        trig = 1'b0;
        while (ms >= 2) begin rand_adc(); tick(); end
        check(busy == 1'b0, "R8", busy, 0);

        // R5: random trigger plus header traffic in mode 01
        mode = 2'b00; tick();
        occ = 0; mode = 2'b01;
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 5;
            trig = (($urandom % 13) == 0);
            set_ch0(r < 2 ? 8'd40 : r < 4 ? 8'd200 : 8'($urandom));
            if (!busy) occ = 0;
            tick();
        end
        wait_idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule